// File: doc/BRIEF.md
# Masked-Match Translation Entry Array

This block holds a small, fully associative set of address translation entries. Each entry stores a virtual page number tag, a per-entry page mask, an address-space identifier and a global flag. It also stores two page halves, even and odd, and each half has its own frame number, cache attribute, dirty flag and valid flag. A combinational search port takes a virtual page number and an address-space identifier. It returns whether any entry matches, the index of the lowest matching entry and a copy of that entry. The tag compare skips every VPN bit that is set in the entry's own mask. An entry with its global flag set matches any address-space identifier.

Maintenance traffic uses the same storage. A probe command reuses the search logic and registers either the matching index or an all-ones miss code. A write port replaces one entry by index, and a write to an index outside the array is dropped. A flush clears the whole array and the replacement pointer. The replacement pointer exposes one entry for reading and can step forward one place, wrapping around at the end of the array, so that software or a refill engine can replace entries in rotation.

Top module: `masked_tlb_array`

## Requirements
- R1: A live entry matches a search key when the key VPN and the stored VPN are equal on every bit position where the entry's mask bit is 0. Bit positions where the mask bit is 1 are not compared. When no entry matches, `lk_hit` is 0 and `lk_entry` is all zeros.
- R2: A matching entry also needs an ASID equal to the key ASID. The exception is an entry whose global flag is 1: it matches regardless of the key ASID.
- R3: A write with `wr_en`=1 and `wr_idx` below NUM_ENTRIES stores `wr_data` at that index at the next rising edge. A later search that hits that entry returns the index in `lk_idx` and the stored word in `lk_entry`. The entry word layout, from LSB upwards, is: odd half (valid bit 0, dirty bit 1, attribute bits 4:2, frame number bits 24:5), then even half at bits 49:25 with the same internal order, then the global flag at bit 50, ASID at bits 58:51, mask at bits 77:59 and VPN at bits 96:78.
- R4: A cycle with `probe_go`=1 registers a result in `probe_res`, visible after the next rising edge. The result is the lowest matching index for the current search key, zero-extended, or all ones if there is no match. `probe_res` holds its value while `probe_go` is 0.
- R5: A write whose `wr_idx` is NUM_ENTRIES or greater changes no entry.
- R6: `flush`=1 clears every entry to all zeros and returns the replacement pointer to 0 at the next edge. It wins over a write and over a pointer advance in the same cycle.
- R7: `nx_idx` shows the replacement pointer and `nx_entry` shows the entry stored at that index. With `nx_adv`=1 the pointer steps by one at the next edge and wraps from NUM_ENTRIES-1 to 0. With `nx_adv`=0 it stays where it is.
- R8: An entry takes part in matching only while at least one of its two valid flags is 1.
- R9: When several entries match, the lowest index is reported.
- R10: After synchronous reset, every entry is zero, the pointer is 0, no search hits and `probe_res` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_vpn | input | 19 | Search key virtual page number |
| lk_asid | input | 8 | Search key address-space identifier |
| lk_hit | output | 1 | Some live entry matches the key |
| lk_idx | output | 4 | Lowest matching index |
| lk_entry | output | 97 | Matching entry word (zero on miss) |
| probe_go | input | 1 | Register a probe result for the current key |
| probe_res | output | 5 | Probe index or all-ones miss code |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write index (out-of-range values are dropped) |
| wr_data | input | 97 | Entry word to store |
| flush | input | 1 | Clear all entries and the pointer |
| nx_adv | input | 1 | Step the replacement pointer |
| nx_idx | output | 4 | Replacement pointer |
| nx_entry | output | 97 | Entry at the replacement pointer |

## Verification
On every cycle, the assertions check these behaviours: an out-of-range write leaves each entry stable, a flush leaves no hit and a zero entry at pointer 0, the pointer wraps, an in-range write lands, and the probe register holds a legal value. They also check that the reported index is a matching entry with no lower matching one. Other behaviours only show up in the bench scenarios. These are the masked compare across swept low and high mask bits, the ASID and global rule, the live rule when valid flags toggle, and the precedence of flush over a write in the same cycle. A full walk of the pointer compares every entry with the contents the bench expects.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VPN_W  = 19;
  localparam int ASID_W = 8;
  localparam int PFN_W  = 20;
  localparam int ATTR_W = 3;

  typedef struct packed {
    logic [PFN_W-1:0]  pfn;
    logic [ATTR_W-1:0] attr;
    logic              dirty;
    logic              valid;
  } page_half_t;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [VPN_W-1:0]  mask;
    logic [ASID_W-1:0] asid;
    logic              glb;
    page_half_t        even;
    page_half_t        odd;
  } tlb_entry_t;

  localparam int ENTRY_W = $bits(tlb_entry_t);
endpackage

// File: rtl/tlb_match_cell.sv
module tlb_match_cell
  import tlb_pkg::*;
(
  input  tlb_entry_t        ent,
  input  logic [VPN_W-1:0]  key_vpn,
  input  logic [ASID_W-1:0] key_asid,
  output logic              match
);
  logic live, vpn_ok, asid_ok;

  always_comb begin
    live    = ent.even.valid | ent.odd.valid;
    vpn_ok  = ((key_vpn ^ ent.vpn) & ~ent.mask) == '0;
    asid_ok = ent.glb | (key_asid == ent.asid);
    match   = live & vpn_ok & asid_ok;
  end
endmodule

// File: rtl/tlb_prio_enc.sv
module tlb_prio_enc #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     req,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        hit = 1'b1;
        idx = i[IDX_W-1:0];
      end
    end
  end

  assert_hit_is_match_R9: assert property (@(posedge clk) disable iff (rst)
    hit |-> req[idx]);
  assert_lowest_wins_R9: assert property (@(posedge clk) disable iff (rst)
    hit |-> ((req & ((ONE << idx) - ONE)) == '0));
  assert_miss_empty_R1: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (req == '0));
endmodule

// File: rtl/tlb_repl_ptr.sv
module tlb_repl_ptr #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  always_ff @(posedge clk) begin
    if (rst || flush)   ptr <= '0;
    else if (adv)       ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  assert_ptr_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (adv && !flush && ptr == LAST) |=> (ptr == '0));
  assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!adv && !flush) |=> $stable(ptr));
  assert_ptr_flush_R6: assert property (@(posedge clk) disable iff (rst)
    flush |=> (ptr == '0));
endmodule

// File: rtl/masked_tlb_array.sv
module masked_tlb_array
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [VPN_W-1:0]               lk_vpn,
  input  logic [ASID_W-1:0]              lk_asid,
  output logic                           lk_hit,
  output logic [$clog2(NUM_ENTRIES)-1:0] lk_idx,
  output logic [ENTRY_W-1:0]             lk_entry,
  input  logic                           probe_go,
  output logic [$clog2(NUM_ENTRIES):0]   probe_res,
  input  logic                           wr_en,
  input  logic [$clog2(NUM_ENTRIES):0]   wr_idx,
  input  logic [ENTRY_W-1:0]             wr_data,
  input  logic                           flush,
  input  logic                           nx_adv,
  output logic [$clog2(NUM_ENTRIES)-1:0] nx_idx,
  output logic [ENTRY_W-1:0]             nx_entry
);
  localparam int IDX_W  = $clog2(NUM_ENTRIES);
  localparam int WIDX_W = IDX_W + 1;
  localparam logic [WIDX_W-1:0] LIMIT = WIDX_W'(NUM_ENTRIES);

  tlb_entry_t             tbl [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] match_vec;
  logic                   wr_ok;

  assign wr_ok = wr_en && (wr_idx < LIMIT);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      for (int i = 0; i < NUM_ENTRIES; i++) tbl[i] <= '0;
    end else if (wr_ok) begin
      tbl[wr_idx[IDX_W-1:0]] <= tlb_entry_t'(wr_data);
    end
  end

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cell
    tlb_match_cell u_cell (
      .ent      (tbl[g]),
      .key_vpn  (lk_vpn),
      .key_asid (lk_asid),
      .match    (match_vec[g])
    );

    assert_oob_write_R5: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !flush && wr_idx >= LIMIT) |=> $stable(tbl[g]));
    assert_write_lands_R3: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !flush && wr_idx == WIDX_W'(g)) |=> (tbl[g] == $past(wr_data)));
  end

  tlb_prio_enc #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_prio (
    .clk (clk),
    .rst (rst),
    .req (match_vec),
    .hit (lk_hit),
    .idx (lk_idx)
  );

  tlb_repl_ptr #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_ptr (
    .clk   (clk),
    .rst   (rst),
    .flush (flush),
    .adv   (nx_adv),
    .ptr   (nx_idx)
  );

  assign lk_entry = lk_hit ? ENTRY_W'(tbl[lk_idx]) : '0;
  assign nx_entry = ENTRY_W'(tbl[nx_idx]);

  always_ff @(posedge clk) begin
    if (rst)           probe_res <= '1;
    else if (probe_go) probe_res <= lk_hit ? {1'b0, lk_idx} : '1;
  end

  assert_probe_range_R4: assert property (@(posedge clk) disable iff (rst)
    (probe_res == '1) || (int'(probe_res) < NUM_ENTRIES));
  assert_probe_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !probe_go |=> $stable(probe_res));
  assert_flush_clears_R6: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!lk_hit && nx_entry == '0));
endmodule

// File: tb/masked_tlb_array_tb_top.sv
module masked_tlb_array_tb_top;
  import tlb_pkg::*;

  localparam int N = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [VPN_W-1:0]  lk_vpn = '0;
  logic [ASID_W-1:0] lk_asid = '0;
  logic              lk_hit;
  logic [3:0]        lk_idx;
  logic [ENTRY_W-1:0] lk_entry;
  logic              probe_go = 1'b0;
  logic [4:0]        probe_res;
  logic              wr_en = 1'b0;
  logic [4:0]        wr_idx = '0;
  logic [ENTRY_W-1:0] wr_data = '0;
  logic              flush = 1'b0;
  logic              nx_adv = 1'b0;
  logic [3:0]        nx_idx;
  logic [ENTRY_W-1:0] nx_entry;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  tlb_entry_t mdl [N];

  always #10 clk = ~clk;

  masked_tlb_array #(.NUM_ENTRIES(N)) dut_i (
    .clk(clk), .rst(rst), .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_hit(lk_hit),
    .lk_idx(lk_idx), .lk_entry(lk_entry), .probe_go(probe_go), .probe_res(probe_res),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .flush(flush),
    .nx_adv(nx_adv), .nx_idx(nx_idx), .nx_entry(nx_entry)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  function automatic tlb_entry_t mk(input int vpn, input int mask, input int asid,
                                    input bit g, input bit v0, input bit v1, input int pfn);
    tlb_entry_t e;
    e.vpn        = VPN_W'(vpn);
    e.mask       = VPN_W'(mask);
    e.asid       = ASID_W'(asid);
    e.glb        = g;
    e.even.pfn   = PFN_W'(pfn);
    e.even.attr  = ATTR_W'(pfn);
    e.even.dirty = v0;
    e.even.valid = v0;
    e.odd.pfn    = PFN_W'(pfn + 1);
    e.odd.attr   = ATTR_W'(pfn + 3);
    e.odd.dirty  = 1'b0;
    e.odd.valid  = v1;
    return e;
  endfunction

  task automatic do_write(input int idx, input tlb_entry_t e);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'(idx); wr_data = e;
    @(negedge clk);
    wr_en = 1'b0;
    if (idx < N) mdl[idx] = e;
  endtask

  task automatic look(input int vpn, input int asid, input bit eh, input int ei,
                      input string req);
    lk_vpn = VPN_W'(vpn); lk_asid = ASID_W'(asid);
    #1;
    chk(lk_hit == eh, req, 128'(lk_hit), 128'(eh));
    if (eh) begin
      chk(lk_idx == 4'(ei), req, 128'(lk_idx), 128'(ei));
      chk(lk_entry == mdl[ei], req, 128'(lk_entry), 128'(mdl[ei]));
    end else begin
      chk(lk_entry == '0, req, 128'(lk_entry), 128'(0));
    end
  endtask

  task automatic probe(input int vpn, input int asid, input logic [4:0] exp, input string req);
    @(negedge clk);
    lk_vpn = VPN_W'(vpn); lk_asid = ASID_W'(asid); probe_go = 1'b1;
    @(negedge clk);
    probe_go = 1'b0;
    chk(probe_res == exp, req, 128'(probe_res), 128'(exp));
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    look(0, 0, 1'b0, 0, "R10");
    chk(nx_idx == 0, "R10", 128'(nx_idx), 0);
    chk(nx_entry == '0, "R10", 128'(nx_entry), 0);
    chk(probe_res == 5'h1F, "R10", 128'(probe_res), 128'h1F);

    // R3: fill all entries with distinct tags
    for (int i = 0; i < N; i++)
      do_write(i, mk(32'h100 + i * 32'h35, 0, i + 1, i == 5, 1'b1, i[0], i * 32'h100));
    for (int i = 0; i < N; i++) begin
      look(32'h100 + i * 32'h35, i + 1, 1'b1, i, "R3");
      look(32'h100 + i * 32'h35, i + 2, i == 5, i, "R2");   // only the global entry ignores ASID
    end
    look(32'h101, 1, 1'b0, 0, "R1");                        // one unmasked bit differs

    // R1: low mask bits swept
    do_write(3, mk(32'h2A0, 32'h00F, 4, 1'b0, 1'b1, 1'b1, 32'h777));
    for (int k = 0; k < 16; k++) look(32'h2A0 | k, 4, 1'b1, 3, "R1");
    look(32'h2B0, 4, 1'b0, 0, "R1");
    // R1: top mask bit
    do_write(7, mk(32'h00123, 32'h40000, 8, 1'b0, 1'b0, 1'b1, 32'h55));
    look(32'h40123, 8, 1'b1, 7, "R1");
    look(32'h00123, 8, 1'b1, 7, "R1");
    look(32'h00122, 8, 1'b0, 0, "R1");

    // R9 and R8: duplicate tags, validity toggling
    do_write(10, mk(32'h5555, 0, 32'h77, 1'b0, 1'b1, 1'b0, 32'hA0));
    do_write(12, mk(32'h5555, 0, 32'h77, 1'b1, 1'b1, 1'b1, 32'hC0));
    look(32'h5555, 32'h77, 1'b1, 10, "R9");
    look(32'h5555, 32'h01, 1'b1, 12, "R2");
    do_write(10, mk(32'h5555, 0, 32'h77, 1'b0, 1'b0, 1'b0, 32'hA0));
    look(32'h5555, 32'h77, 1'b1, 12, "R8");
    do_write(10, mk(32'h5555, 0, 32'h77, 1'b0, 1'b0, 1'b1, 32'hA0));
    look(32'h5555, 32'h77, 1'b1, 10, "R8");

    // R4: probe
    probe(32'h5555, 32'h77, 5'd10, "R4");
    probe(32'h6666, 1, 5'h1F, "R4");
    probe(32'h100 + 15 * 32'h35, 16, 5'd15, "R4");
    @(negedge clk);
    chk(probe_res == 5'd15, "R4", 128'(probe_res), 15);

    // R5: every out-of-range index dropped
    for (int w = N; w < 32; w++) do_write(w, mk(32'h7777, 0, 32'h33, 1'b1, 1'b1, 1'b1, w));
    look(32'h7777, 32'h33, 1'b0, 0, "R5");

    // R7: full pointer walk with wrap; also confirms R5 left contents intact
    for (int k = 0; k <= N; k++) begin
      chk(nx_idx == 4'(k % N), "R7", 128'(nx_idx), 128'(k % N));
      chk(nx_entry == mdl[k % N], "R5", 128'(nx_entry), 128'(mdl[k % N]));
      @(negedge clk); nx_adv = 1'b1;
      @(negedge clk); nx_adv = 1'b0;
    end
    chk(nx_idx == 4'd1, "R7", 128'(nx_idx), 1);

    // R6: flush beats write and advance in the same cycle
    @(negedge clk);
    flush = 1'b1; nx_adv = 1'b1; wr_en = 1'b1; wr_idx = 5'd2;
    wr_data = mk(32'h3333, 0, 9, 1'b0, 1'b1, 1'b1, 1);
    @(negedge clk);
    flush = 1'b0; nx_adv = 1'b0; wr_en = 1'b0;
    for (int i = 0; i < N; i++) mdl[i] = '0;
    look(32'h3333, 9, 1'b0, 0, "R6");
    look(32'h5555, 32'h77, 1'b0, 0, "R6");
    chk(nx_idx == 0, "R6", 128'(nx_idx), 0);
    chk(nx_entry == '0, "R6", 128'(nx_entry), 0);
    do_write(0, mk(32'h3333, 0, 9, 1'b0, 1'b1, 1'b0, 2));
    look(32'h3333, 9, 1'b1, 0, "R3");

    finish_run();
  end
endmodule